// File: doc/BRIEF.md
# PCM Line Retimer with Loss-of-Activity Alarm

This block takes a half-baud PCM data stream and its companion line clock and turns them into a full-baud retimed stream. The bit on the data line is captured at every rising edge of the line clock and is held until the next rising edge. The retimed stream leaves the block in inverted form, and a regenerated copy of the line clock leaves with it. Both line signals are first brought into a free-running system clock domain through two-flop synchronizers. All timing in the block is counted in cycles of that system clock.

Two supervisors of the same design watch the link. One is fired by falling transitions of the inverted retimed data. The other is fired by rising edges of the line clock. Each trigger opens a window of a fixed number of system cycles. A new trigger that arrives inside the window starts the full window again. If either window runs out, the block raises a combined link-fail alarm and turns its status lamp off. The alarm is raised from reset until both supervisors have seen traffic.

Top module: `pcm_retimer_alarm`

## Requirements
- R1: Each line input passes through two synchronizer flops. A line_clk_i rising edge first sampled at system edge n is acted on at system edge n+2, together with the line_data_i value sampled at edge n.
- R2: retimed_data_no is the complement of the data bit captured at each line-clock rising edge. It changes only after the system edge where that rising edge is acted on, and it holds its value between rising edges.
- R3: clk_o is the synchronized line clock. After system edge n+2 it equals the line_clk_i value sampled at edge n.
- R4: The data supervisor is triggered when retimed_data_no falls, which means the captured bit goes from 0 to 1. After a trigger at edge t, data_active_o is high after edges t through t+WIN_CYC-1.
- R5: A trigger inside a running window reloads the full window. Triggers spaced at most WIN_CYC edges apart keep the detector output high without a break. A spacing of WIN_CYC+1 edges gives exactly one low cycle.
- R6: The clock supervisor has the same timing as the data supervisor. It is triggered at every line-clock rising edge that is acted on, and it drives clk_active_o.
- R7: link_fail_o is high exactly when data_active_o or clk_active_o is low.
- R8: lamp_on_o is always the complement of link_fail_o.
- R9: In reset the outputs are as follows: retimed_data_no=1, clk_o=0, data_active_o=0, clk_active_o=0, link_fail_o=1 and lamp_on_o=0.
- R10: If data stops rising while the clock keeps running, link_fail_o rises within WIN_CYC+3 system cycles of the last rising data edge, and clk_active_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_clk_i | input | 1 | Line clock, asynchronous to the system clock |
| line_data_i | input | 1 | Half-baud PCM data |
| retimed_data_no | output | 1 | Full-baud retimed data, inverted |
| clk_o | output | 1 | Regenerated line clock |
| data_active_o | output | 1 | Data supervisor window open |
| clk_active_o | output | 1 | Clock supervisor window open |
| link_fail_o | output | 1 | Combined loss-of-activity alarm |
| lamp_on_o | output | 1 | Status lamp drive, lit while the link is healthy |

## Verification
A new trigger and the expiry of a window can fall on the same system cycle. The bench provokes this by spacing line-clock pulses exactly WIN_CYC cycles apart, where the reload must win and no low cycle may appear, and then WIN_CYC+1 cycles apart, where exactly one low cycle per gap is expected. Capture of a new data bit and the firing of both supervisors also share one edge; a behavioural reference model judges this on every clock for every output.

// File: rtl/pcm_retimer_pkg.sv
package pcm_retimer_pkg;
  typedef struct packed {
    logic clk;
    logic data;
  } line_smp_t;

  localparam int NUM_DET  = 2;
  localparam int DET_DATA = 0;
  localparam int DET_CLK  = 1;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else if (i == 0) stg_q[i] <= d_i;
      else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pcm_retime_core.sv
module pcm_retime_core
  import pcm_retimer_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  line_smp_t          smp_i,
  output logic               retimed_no,
  output logic               clk_o,
  output logic [NUM_DET-1:0] trig_o
);
  logic clk_q, cap_q, rise;

  assign rise = smp_i.clk & ~clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q <= 1'b0;
      cap_q <= 1'b0;
    end else begin
      clk_q <= smp_i.clk;
      if (rise) cap_q <= smp_i.data;
    end
  end

  // data trigger: captured bit 0->1, i.e. inverted output falls
  assign trig_o[DET_DATA] = rise & smp_i.data & ~cap_q;
  assign trig_o[DET_CLK]  = rise;
  assign retimed_no = ~cap_q;
  assign clk_o      = clk_q;
endmodule

// File: rtl/pcm_act_det.sv
module pcm_act_det #(
  parameter int unsigned WIN_CYC = 7200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (trig_i)          cnt_q <= CW'(WIN_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/pcm_alarm_comb.sv
module pcm_alarm_comb #(
  parameter int N = 2
) (
  input  logic [N-1:0] active_i,
  output logic         fail_o,
  output logic         lamp_o
);
  assign fail_o = ~(&active_i);
  assign lamp_o = &active_i;
endmodule

// File: rtl/pcm_retimer_alarm.sv
module pcm_retimer_alarm
  import pcm_retimer_pkg::*;
#(
  parameter int unsigned WIN_CYC     = 7200,
  parameter int          SYNC_STAGES = 2
) (
  input  logic sys_clk_i,
  input  logic rst_ni,
  input  logic line_clk_i,
  input  logic line_data_i,
  output logic retimed_data_no,
  output logic clk_o,
  output logic data_active_o,
  output logic clk_active_o,
  output logic link_fail_o,
  output logic lamp_on_o
);
  localparam int SW = $bits(line_smp_t);

  line_smp_t          raw, smp;
  logic [NUM_DET-1:0] trig, active;

  assign raw.clk  = line_clk_i;
  assign raw.data = line_data_i;

  pcm_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (sys_clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (smp)
  );

  pcm_retime_core u_core (
    .clk_i     (sys_clk_i),
    .rst_ni    (rst_ni),
    .smp_i     (smp),
    .retimed_no(retimed_data_no),
    .clk_o     (clk_o),
    .trig_o    (trig)
  );

  for (genvar d = 0; d < NUM_DET; d++) begin : g_det
    pcm_act_det #(.WIN_CYC(WIN_CYC)) u_det (
      .clk_i   (sys_clk_i),
      .rst_ni  (rst_ni),
      .trig_i  (trig[d]),
      .active_o(active[d])
    );
  end

  pcm_alarm_comb #(.N(NUM_DET)) u_alarm (
    .active_i(active),
    .fail_o  (link_fail_o),
    .lamp_o  (lamp_on_o)
  );

  assign data_active_o = active[DET_DATA];
  assign clk_active_o  = active[DET_CLK];
endmodule

// File: rtl/pcm_retimer_alarm_chk.sv
module pcm_retimer_alarm_chk (
  input logic sys_clk_i,
  input logic rst_ni,
  input logic clk_rise_i,
  input logic data_trig_i,
  input logic retimed_data_no,
  input logic clk_o,
  input logic data_active_o,
  input logic clk_active_o,
  input logic link_fail_o,
  input logic lamp_on_o
);
  a_r2_hold_between_rises: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    !clk_rise_i |=> $stable(retimed_data_no));

  a_r3_clk_follows_rise: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    clk_rise_i |=> clk_o);

  a_r4_data_trig_opens: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    data_trig_i |=> data_active_o);

  a_r5_rise_needs_trig: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    $rose(data_active_o) |-> $past(data_trig_i));

  a_r6_clk_trig_opens: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    clk_rise_i |=> clk_active_o);

  a_r7_fail_combine: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    link_fail_o == !(data_active_o && clk_active_o));

  a_r8_lamp_inverse: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    lamp_on_o != link_fail_o);
endmodule

bind pcm_retimer_alarm pcm_retimer_alarm_chk u_chk (
  .sys_clk_i      (sys_clk_i),
  .rst_ni         (rst_ni),
  .clk_rise_i     (trig[pcm_retimer_pkg::DET_CLK]),
  .data_trig_i    (trig[pcm_retimer_pkg::DET_DATA]),
  .retimed_data_no(retimed_data_no),
  .clk_o          (clk_o),
  .data_active_o  (data_active_o),
  .clk_active_o   (clk_active_o),
  .link_fail_o    (link_fail_o),
  .lamp_on_o      (lamp_on_o)
);

// File: tb/sim_pcm_retimer_alarm.sv
module sim_pcm_retimer_alarm;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 20;

  logic sys_clk = 1'b0, rst_n = 1'b0, lclk = 1'b0, ldata = 1'b0;
  logic rd_n, clko, dact, cact, fail, lamp;

  always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

  pcm_retimer_alarm #(.WIN_CYC(WIN), .SYNC_STAGES(2)) u0 (
    .sys_clk_i(sys_clk), .rst_ni(rst_n), .line_clk_i(lclk), .line_data_i(ldata),
    .retimed_data_no(rd_n), .clk_o(clko), .data_active_o(dact),
    .clk_active_o(cact), .link_fail_o(fail), .lamp_on_o(lamp)
  );

  int n_vec = 0, n_bad = 0;

  task automatic cmp(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: sample history, trigger times
  bit hc[$], hd[$];
  bit m_run = 0, m_cap = 0, m_clko = 0;
  int ecnt = 0, last_dt = -100000, last_ct = -100000;
  bit s_c, p_c, s_d;

  always @(posedge sys_clk) if (m_run) begin
    hc.push_back(lclk);
    hd.push_back(ldata);
    ecnt++;
    s_c = hc[hc.size()-3];  // R1: two-stage latency
    p_c = hc[hc.size()-4];
    s_d = hd[hd.size()-3];
    if (s_c && !p_c) begin
      if (s_d && !m_cap) last_dt = ecnt;
      m_cap   = s_d;
      last_ct = ecnt;
    end
    m_clko = s_c;
  end

  bit mon_en = 0;
  int mon_low = 0;

  always @(negedge sys_clk) if (m_run) begin
    automatic bit ed = (ecnt - last_dt) < WIN;
    automatic bit ec = (ecnt - last_ct) < WIN;
    cmp("R2 retimed_data_no", rd_n, ~m_cap);
    cmp("R3 clk_o", clko, m_clko);
    cmp("R4 data_active", dact, ed);
    cmp("R6 clk_active", cact, ec);
    cmp("R7 link_fail", fail, ~(ed & ec));
    cmp("R8 lamp_on", lamp, ed & ec);
    if (mon_en && !cact) mon_low++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  // one 4-cycle bit, data pulse straddles the clock rise
  task automatic send_bit(input bit b);
    ldata = b; lclk = 1'b0; tick(1);
    lclk = 1'b1; tick(1);
    ldata = 1'b0; tick(1);
    lclk = 1'b0; tick(1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    hc = '{0, 0, 0};
    hd = '{0, 0, 0};
    tick(3);
    // R9 reset state
    cmp("R9 retimed_data_no", rd_n, 1'b1);
    cmp("R9 clk_o", clko, 1'b0);
    cmp("R9 data_active", dact, 1'b0);
    cmp("R9 clk_active", cact, 1'b0);
    cmp("R9 link_fail", fail, 1'b1);
    cmp("R9 lamp_on", lamp, 1'b0);
    rst_n = 1'b1;
    m_run = 1;
    // pseudo-random traffic
    for (int i = 0; i < 80; i++) begin
      send_bit(lfsr[0]);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    // steady alternating traffic
    for (int i = 0; i < 20; i++) send_bit(i[0]);
    cmp("R7 steady traffic no alarm", fail, 1'b0);
    cmp("R8 steady traffic lamp lit", lamp, 1'b1);
    // data stall, clock running: last data rise long past WIN+3
    for (int i = 0; i < 15; i++) send_bit(1'b0);
    cmp("R10 data stall alarm", fail, 1'b1);
    cmp("R10 clock still active", cact, 1'b1);
    cmp("R4 data inactive", dact, 1'b0);
    for (int i = 0; i < 10; i++) send_bit(i[0]);
    cmp("R7 recovered", fail, 1'b0);
    // clock stall
    ldata = 1'b1; lclk = 1'b0;
    tick(WIN + 10);
    cmp("R6 clock stall inactive", cact, 1'b0);
    cmp("R7 clock stall alarm", fail, 1'b1);
    for (int i = 0; i < 10; i++) send_bit(i[0]);
    cmp("R6 clock recovered", cact, 1'b1);
    // R5 boundary: rise spacing exactly WIN
    mon_low = 0; mon_en = 1;
    for (int i = 0; i < 4; i++) begin
      lclk = 1'b1; tick(2);
      lclk = 1'b0; tick(WIN - 2);
    end
    mon_en = 0;
    n_vec++;
    if (mon_low != 0) begin
      n_bad++;
      $display("FAIL R5 spacing WIN low cycles act=%0d exp=0", mon_low);
    end
    // spacing WIN+1: one low cycle per gap
    mon_low = 0; mon_en = 1;
    for (int i = 0; i < 4; i++) begin
      lclk = 1'b1; tick(2);
      lclk = 1'b0; tick(i == 3 ? 2 : WIN - 1);
    end
    mon_en = 0;
    n_vec++;
    if (mon_low != 3) begin
      n_bad++;
      $display("FAIL R5 spacing WIN+1 low cycles act=%0d exp=3", mon_low);
    end
    tick(WIN + 5);
    cmp("R6 final expiry", cact, 1'b0);
    finish_run();
  end
endmodule